// File: doc/BRIEF.md
# Set-Associative Cache Miss Classifier

This block is a tag-only model of a two-way set-associative cache with 256 block frames in 128 sets and least-recently-used replacement. It takes one memory block number per valid cycle and decides whether that access would hit, miss on a block never referenced before (a compulsory miss), or miss on a block that was referenced earlier and has since been displaced from its set (a conflict miss). No data, write policy or backing store is modelled. Only tags, valid bits, one replacement bit per set and a record of every block ever touched are kept.

The verdict for each access appears as a one-cycle strobe in the cycle after the access. Three saturating counters keep running totals of the three outcomes. A synchronous clear empties the cache, forgets all history and zeroes the counters. Capacity misses are not a separate category: every miss on a block that has been touched before counts as a conflict.

Top module: `lru_miss_sorter`

## Requirements
- R1: The set index is bits [6:0] of the 9-bit block number and the tag is bits [8:7]. Blocks in different sets never affect each other.
- R2: An access whose tag is held in a valid way of its set is a hit.
- R3: On a miss where a way of the set is still invalid, that way is filled (way 0 before way 1) and no valid block is evicted.
- R4: On a miss in a full set, the least-recently-used way is replaced. Every access, hit or miss, makes the touched way the most recently used.
- R5: A miss on a block number never accessed since reset or clear is reported as compulsory.
- R6: A miss on a block number accessed before is reported as conflict.
- R7: For every cycle with `acc_valid` high and `clr` low, exactly one of `res_hit`, `res_compulsory`, `res_conflict` is high in the next cycle. All three are low in the cycle after an idle cycle.
- R8: Each 16-bit counter increases by one in the same cycle as its strobe, and holds at 65535 once it reaches that value.
- R9: A cycle with `clr` high invalidates every way, forgets every touched block and makes all counters zero in the next cycle. An access presented together with `clr` is ignored.
- R10: After reset the cache is empty, the counters are zero and no strobe is high.
- R11: The 16-access pattern 0,128,256,128,0,128,256,128,1,129,257,129,1,129,257,129 applied ten times in a row gives 76 conflict misses (4 in the first pass, 8 in each later pass), 6 compulsory misses and 78 hits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| clr | input | 1 | Synchronous clear of cache, touch record and counters |
| acc_valid | input | 1 | An access is presented this cycle |
| acc_block | input | 9 | Memory block number of the access |
| res_hit | output | 1 | One-cycle strobe: previous access hit |
| res_compulsory | output | 1 | One-cycle strobe: previous access was a first-touch miss |
| res_conflict | output | 1 | One-cycle strobe: previous access missed on a known block |
| hit_cnt | output | 16 | Saturating count of hits |
| comp_cnt | output | 16 | Saturating count of compulsory misses |
| conf_cnt | output | 16 | Saturating count of conflict misses |

## Verification
The hardest state to reach is a full set whose replacement bit points at a particular way while the block that arrives has been seen before, because compulsory misses mask it unless the history is built up first. The bench gets there with the repeated ten-pass pattern and directed sequences within one set, then with full ascending and descending sweeps over all 512 block numbers. These sweeps walk every set through fill, eviction and re-reference, and each strobe is compared against an arithmetic model in the bench. Counter saturation is reached by a long run of repeated hits after a clear.

// File: rtl/lru_miss_pkg.sv
package lru_miss_pkg;
  typedef enum logic [1:0] {
    OUT_HIT  = 2'd0,
    OUT_COMP = 2'd1,
    OUT_CONF = 2'd2
  } outcome_e;

  localparam int unsigned NUM_OUTCOMES = 3;

  function automatic logic [NUM_OUTCOMES-1:0] outcome_onehot(outcome_e o);
    logic [NUM_OUTCOMES-1:0] v;
    v = '0;
    v[o] = 1'b1;
    return v;
  endfunction
endpackage

// File: rtl/lms_rst_sync.sv
module lms_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_ok
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_ok = sync_q[1];
endmodule

// File: rtl/lms_tag_store.sv
module lms_tag_store #(
  parameter int unsigned SET_W = 7,
  parameter int unsigned TAG_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             upd_en,
  input  logic [SET_W-1:0] idx,
  input  logic [TAG_W-1:0] tag,
  output logic             hit
);
  localparam int unsigned SETS = 1 << SET_W;

  logic [TAG_W-1:0] tag_q [SETS][2];
  logic [1:0]       vld_q [SETS];
  logic [SETS-1:0]  lru_q;        // way to evict next, per set

  logic [1:0] way_hit;
  logic       sel_way;

  // lookup and victim choice
  always_comb begin
    for (int w = 0; w < 2; w++) begin
      way_hit[w] = vld_q[idx][w] && (tag_q[idx][w] == tag);
    end
    hit = |way_hit;
    if (way_hit[0])          sel_way = 1'b0;
    else if (way_hit[1])     sel_way = 1'b1;
    else if (!vld_q[idx][0]) sel_way = 1'b0;
    else if (!vld_q[idx][1]) sel_way = 1'b1;
    else                     sel_way = lru_q[idx];
  end

  // state bits: valid and replacement order
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lru_q <= '0;
      for (int s = 0; s < SETS; s++) vld_q[s] <= 2'b00;
    end else if (clr) begin
      lru_q <= '0;
      for (int s = 0; s < SETS; s++) vld_q[s] <= 2'b00;
    end else if (upd_en) begin
      vld_q[idx][sel_way] <= 1'b1;
      lru_q[idx]          <= ~sel_way;
    end
  end

  // tag storage carries no reset; valid bits qualify it
  always_ff @(posedge clk) begin
    if (upd_en && !clr) tag_q[idx][sel_way] <= tag;
  end
endmodule

// File: rtl/lms_touch_map.sv
module lms_touch_map #(
  parameter int unsigned BLK_W = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             mark_en,
  input  logic [BLK_W-1:0] blk,
  output logic             seen
);
  localparam int unsigned NBLK = 1 << BLK_W;

  logic [NBLK-1:0] seen_q, seen_d;

  always_comb begin
    seen_d = seen_q;
    if (clr)          seen_d = '0;
    else if (mark_en) seen_d[blk] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) seen_q <= '0;
    else        seen_q <= seen_d;
  end

  assign seen = seen_q[blk];
endmodule

// File: rtl/lms_sat_counter.sv
module lms_sat_counter #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             inc,
  output logic [CNT_W-1:0] cnt
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (clr)                         cnt_d = '0;
    else if (inc && cnt_q != CNT_MAX) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign cnt = cnt_q;
endmodule

// File: rtl/lru_miss_sorter.sv
module lru_miss_sorter #(
  parameter int unsigned BLK_W = 9,
  parameter int unsigned SET_W = 7,
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             acc_valid,
  input  logic [BLK_W-1:0] acc_block,
  output logic             res_hit,
  output logic             res_compulsory,
  output logic             res_conflict,
  output logic [CNT_W-1:0] hit_cnt,
  output logic [CNT_W-1:0] comp_cnt,
  output logic [CNT_W-1:0] conf_cnt
);
  import lru_miss_pkg::*;

  localparam int unsigned TAG_W = BLK_W - SET_W;

  logic                    rst_ok;
  logic                    take;
  logic                    way_hit;
  logic                    seen;
  outcome_e                verdict;
  logic [NUM_OUTCOMES-1:0] strb_d, strb_q;
  logic [CNT_W-1:0]        cnt_v [NUM_OUTCOMES];

  lms_rst_sync u_rst (
    .clk    (clk),
    .rst_n  (rst_n),
    .rst_ok (rst_ok)
  );

  assign take = acc_valid && !clr;

  lms_tag_store #(.SET_W(SET_W), .TAG_W(TAG_W)) u_tags (
    .clk    (clk),
    .rst_n  (rst_ok),
    .clr    (clr),
    .upd_en (take),
    .idx    (acc_block[SET_W-1:0]),
    .tag    (acc_block[BLK_W-1:SET_W]),
    .hit    (way_hit)
  );

  lms_touch_map #(.BLK_W(BLK_W)) u_touch (
    .clk     (clk),
    .rst_n   (rst_ok),
    .clr     (clr),
    .mark_en (take),
    .blk     (acc_block),
    .seen    (seen)
  );

  always_comb begin
    if (way_hit)   verdict = OUT_HIT;
    else if (seen) verdict = OUT_CONF;
    else           verdict = OUT_COMP;
    strb_d = take ? outcome_onehot(verdict) : '0;
  end

  always_ff @(posedge clk or negedge rst_ok) begin
    if (!rst_ok) strb_q <= '0;
    else         strb_q <= strb_d;
  end

  for (genvar g = 0; g < NUM_OUTCOMES; g++) begin : g_cnt
    lms_sat_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk   (clk),
      .rst_n (rst_ok),
      .clr   (clr),
      .inc   (strb_d[g]),
      .cnt   (cnt_v[g])
    );
  end

  assign res_hit        = strb_q[OUT_HIT];
  assign res_compulsory = strb_q[OUT_COMP];
  assign res_conflict   = strb_q[OUT_CONF];
  assign hit_cnt        = cnt_v[OUT_HIT];
  assign comp_cnt       = cnt_v[OUT_COMP];
  assign conf_cnt       = cnt_v[OUT_CONF];
endmodule

// File: rtl/lru_miss_sorter_chk.sv
module lru_miss_sorter_chk #(
  parameter int unsigned BLK_W = 9,
  parameter int unsigned CNT_W = 16
) (
  input logic             clk,
  input logic             rst_ok,
  input logic             clr,
  input logic             acc_valid,
  input logic [BLK_W-1:0] acc_block,
  input logic             res_hit,
  input logic             res_compulsory,
  input logic             res_conflict,
  input logic [CNT_W-1:0] hit_cnt,
  input logic [CNT_W-1:0] comp_cnt,
  input logic [CNT_W-1:0] conf_cnt
);
  localparam logic [CNT_W-1:0] CMAX = '1;

  p_single_strobe_r7: assert property (@(posedge clk) disable iff (!rst_ok)
    (acc_valid && !clr) |=> ($countones({res_hit, res_compulsory, res_conflict}) == 1));

  p_quiet_idle_r7: assert property (@(posedge clk) disable iff (!rst_ok)
    (!acc_valid || clr) |=> ({res_hit, res_compulsory, res_conflict} == 3'b000));

  p_clear_zero_r9: assert property (@(posedge clk) disable iff (!rst_ok)
    clr |=> (hit_cnt == '0 && comp_cnt == '0 && conf_cnt == '0));

  p_hit_hold_r8: assert property (@(posedge clk) disable iff (!rst_ok)
    (hit_cnt == CMAX && !clr) |=> (hit_cnt == CMAX));

  p_hit_step_r8: assert property (@(posedge clk) disable iff (!rst_ok)
    (hit_cnt != CMAX && !clr) |=> (hit_cnt == $past(hit_cnt) + CNT_W'(res_hit)));

  p_conf_step_r8: assert property (@(posedge clk) disable iff (!rst_ok)
    (conf_cnt != CMAX && !clr) |=> (conf_cnt == $past(conf_cnt) + CNT_W'(res_conflict)));

  p_repeat_hit_r2: assert property (@(posedge clk) disable iff (!rst_ok)
    (acc_valid && !clr && $past(acc_valid && !clr) && acc_block == $past(acc_block))
    |=> res_hit);
endmodule

bind lru_miss_sorter lru_miss_sorter_chk #(.BLK_W(BLK_W), .CNT_W(CNT_W)) u_chk (
  .clk            (clk),
  .rst_ok         (rst_ok),
  .clr            (clr),
  .acc_valid      (acc_valid),
  .acc_block      (acc_block),
  .res_hit        (res_hit),
  .res_compulsory (res_compulsory),
  .res_conflict   (res_conflict),
  .hit_cnt        (hit_cnt),
  .comp_cnt       (comp_cnt),
  .conf_cnt       (conf_cnt)
);

// File: tb/test_lru_miss_sorter.sv
module test_lru_miss_sorter;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        clr = 1'b0;
  logic        acc_valid = 1'b0;
  logic [8:0]  acc_block = '0;
  logic        res_hit, res_compulsory, res_conflict;
  logic [15:0] hit_cnt, comp_cnt, conf_cnt;

  always #4ns clk = ~clk;

  lru_miss_sorter i_lru_miss_sorter (
    .clk(clk), .rst_n(rst_n), .clr(clr), .acc_valid(acc_valid), .acc_block(acc_block),
    .res_hit(res_hit), .res_compulsory(res_compulsory), .res_conflict(res_conflict),
    .hit_cnt(hit_cnt), .comp_cnt(comp_cnt), .conf_cnt(conf_cnt)
  );

  int checks = 0, errors = 0;
  bit done = 0;

  // reference: 0 hit, 1 compulsory, 2 conflict
  logic [1:0] mtag [128][2];
  bit         mval [128][2];
  bit         mlru [128];
  bit         mtouch [512];
  int         e_hit, e_comp, e_conf;

  task automatic chk(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic model_clear();
    for (int s = 0; s < 128; s++) begin
      mval[s][0] = 0; mval[s][1] = 0; mlru[s] = 0;
    end
    for (int b = 0; b < 512; b++) mtouch[b] = 0;
    e_hit = 0; e_comp = 0; e_conf = 0;
  endtask

  function automatic int model_step(int blk);
    int s, t, w, k;
    s = blk % 128; t = blk / 128;
    if (mval[s][0] && mtag[s][0] == t[1:0])      begin w = 0; k = 0; end
    else if (mval[s][1] && mtag[s][1] == t[1:0]) begin w = 1; k = 0; end
    else begin
      k = mtouch[blk] ? 2 : 1;
      if (!mval[s][0])      w = 0;
      else if (!mval[s][1]) w = 1;
      else                  w = mlru[s];
    end
    mval[s][w] = 1; mtag[s][w] = t[1:0]; mlru[s] = (w == 0);
    mtouch[blk] = 1;
    if (k == 0 && e_hit  < 65535) e_hit++;
    if (k == 1 && e_comp < 65535) e_comp++;
    if (k == 2 && e_conf < 65535) e_conf++;
    return k;
  endfunction

  // drive at a falling edge, result visible at the next falling edge
  task automatic acc(int blk, int expk = -1, string req = "R7");
    int k, e;
    logic [2:0] got;
    acc_valid = 1'b1; acc_block = 9'(blk);
    k = model_step(blk);
    e = (expk >= 0) ? expk : k;
    @(negedge clk);
    got = {res_conflict, res_compulsory, res_hit};
    chk(got == 3'(1 << e), req, $sformatf("outcome of block %0d (bit0 hit,bit1 comp,bit2 conf)", blk),
        int'(got), 1 << e);
  endtask

  task automatic idle_chk(string req);
    acc_valid = 1'b0;
    @(negedge clk);
    chk({res_conflict, res_compulsory, res_hit} == 3'b000, req, "strobes after idle cycle",
        int'({res_conflict, res_compulsory, res_hit}), 0);
  endtask

  task automatic cnt_chk(string req);
    chk(hit_cnt  == 16'(e_hit),  req, "hit_cnt",  hit_cnt,  e_hit);
    chk(comp_cnt == 16'(e_comp), req, "comp_cnt", comp_cnt, e_comp);
    chk(conf_cnt == 16'(e_conf), req, "conf_cnt", conf_cnt, e_conf);
  endtask

  task automatic do_clear(bit with_access);
    clr = 1'b1; acc_valid = with_access; acc_block = 9'd0;
    @(negedge clk);
    clr = 1'b0; acc_valid = 1'b0;
    model_clear();
    chk({res_conflict, res_compulsory, res_hit} == 3'b000, "R9", "strobes after clear",
        int'({res_conflict, res_compulsory, res_hit}), 0);
    cnt_chk("R9");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL R7 watchdog: actual 200000 cycles expected completion earlier");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    model_clear();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R10: reset state
    chk({res_conflict, res_compulsory, res_hit} == 3'b000, "R10", "strobes after reset",
        int'({res_conflict, res_compulsory, res_hit}), 0);
    cnt_chk("R10");

    // R11: ten passes of the pattern
    for (int p = 0; p < 10; p++) begin
      for (int h = 0; h < 2; h++) begin
        acc(h + 0); acc(h + 128); acc(h + 256); acc(h + 128);
        acc(h + 0); acc(h + 128); acc(h + 256); acc(h + 128);
      end
      if (p == 0) chk(conf_cnt == 16'd4,  "R11", "conflicts after pass 1", conf_cnt, 4);
      if (p == 1) chk(conf_cnt == 16'd12, "R11", "conflicts after pass 2", conf_cnt, 12);
    end
    chk(conf_cnt == 16'd76, "R11", "conflicts after ten passes", conf_cnt, 76);
    chk(comp_cnt == 16'd6,  "R11", "compulsory after ten passes", comp_cnt, 6);
    chk(hit_cnt  == 16'd78, "R8",  "hits after ten passes", hit_cnt, 78);
    idle_chk("R7");

    // R9: clear wins over a simultaneous access, history forgotten
    do_clear(1'b1);
    acc(0, 1, "R9");
    acc(1, 1, "R5");
    acc(0, 0, "R1");        // other set left it alone
    acc(128, 1, "R3");      // fills way 1, keeps block 0
    acc(0, 0, "R3");
    acc(128, 0, "R3");
    acc(256, 1, "R4");      // evicts 0 (least recent)
    acc(128, 0, "R4");
    acc(0, 2, "R6");        // evicts 256
    acc(256, 2, "R4");      // evicts 128
    acc(0, 0, "R4");
    acc(127, 1, "R1");
    acc(255, 1, "R1");
    acc(127, 0, "R2");
    idle_chk("R7");
    cnt_chk("R8");

    // sweeps over every block number
    do_clear(1'b0);
    for (int b = 0; b < 512; b++) acc(b, -1, "R5");
    for (int b = 0; b < 512; b++) acc(b, -1, "R6");
    for (int b = 511; b >= 0; b--) acc(b, -1, "R4");
    idle_chk("R7");
    cnt_chk("R8");
    chk(comp_cnt == 16'd512, "R5", "compulsory after sweeps", comp_cnt, 512);

    // R8 saturation
    do_clear(1'b0);
    for (int i = 0; i < 65540; i++) acc(5);
    idle_chk("R7");
    chk(hit_cnt == 16'd65535, "R8", "saturated hit_cnt", hit_cnt, 65535);
    chk(comp_cnt == 16'd1, "R8", "comp_cnt during saturation run", comp_cnt, 1);
    cnt_chk("R8");

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule